// File: doc/BRIEF.md
# SGI Pending-State Register Bank

This block holds, for one processor, the pending and active state of sixteen software-generated interrupts, kept apart for each of up to eight source processors. Every (SGI, source) pair has its own two-bit state: inactive, pending, active, or active-and-pending. Three event inputs drive these states. A raise input marks a pair pending. An acknowledge input takes a pending pair into service. An end-of-interrupt input retires an active pair.

Software sees the pending bits through a window of four 32-bit words on a simple byte-enabled bus. Word n sits at byte offset 0xF10 + 4n of the frame. Byte lane x of that word covers SGI 4n + x, and bit k of the lane is source processor k.

A read returns the pending bits. Writing 1 to a bit withdraws that pending state. While the routing-mode input is high the window is dead: reads give zero and writes do nothing. The full pending and active state is also exported as flat vectors for downstream arbitration.

Top module: `sgi_pend_bank`

## Requirements
- R1: After synchronous reset every pending and active bit is 0, and every window read returns 0.
- R2: A raise (`set_vld`) for an implemented source makes that pair pending (bit 8*sgi+src of `pend_mask`) after the next clock edge.
- R3: A read at offset 0xF10+4n returns in bit 8x+k whether SGI 4n+x from source k is pending or active-and-pending; `bus_rdata` follows the addressed word in the same cycle.
- R4: Writing 1 to a bit of a pending, non-active pair makes it inactive.
- R5: Writing 1 to a bit of an active-and-pending pair leaves it active, with the pending bit cleared and the active bit kept.
- R6: Data bits written as 0, and byte lanes whose `bus_be` bit is 0, change nothing.
- R7: A raise and a clear that hit the same pair in one cycle leave the pair pending.
- R8: An acknowledge of a pending pair makes it active. If a raise of the same pair comes in the same cycle, the pair becomes active-and-pending. An acknowledge of a pair that is not pending has no effect.
- R9: End-of-interrupt makes an active pair inactive and an active-and-pending pair pending. On a pair that is not active it has no effect.
- R10: While `route_mode` is 1, window reads return 0 and window writes change no state.
- R11: Sources numbered NUM_SRC or above have no state: their bits read 0, and raises and clears aimed at them are ignored.
- R12: Accesses outside the four window words read 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| route_mode | input | 1 | 1 disables the clear-pending window |
| set_vld | input | 1 | Raise an SGI from a source |
| set_sgi | input | 4 | SGI number of the raise |
| set_src | input | 3 | Source processor of the raise |
| ack_vld | input | 1 | Acknowledge a pair |
| ack_sgi | input | 4 | SGI number of the acknowledge |
| ack_src | input | 3 | Source of the acknowledge |
| eoi_vld | input | 1 | End-of-interrupt for a pair |
| eoi_sgi | input | 4 | SGI number of the end-of-interrupt |
| eoi_src | input | 3 | Source of the end-of-interrupt |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address within the frame |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data, 1 clears pending |
| bus_rdata | output | 32 | Read data, combinational |
| pend_mask | output | 128 | Pending bit of pair 8*sgi+src |
| act_mask | output | 128 | Active bit of pair 8*sgi+src |

## Verification
The assertions assume that the address is word-aligned and is held stable across a bus cycle. They also assume that an acknowledge only names a pair software can legally take, yet the properties are written so that they still hold when acknowledge or end-of-interrupt arrives on a pair in the wrong state. The stimulus drives every input on the falling edge, so the design samples settled values. Random traffic draws addresses mostly from the four window words, with a few outside the window. It aims raises at absent sources and toggles routing mode only now and then, so that both the open window and the dead window carry real clears.

// File: rtl/sgi_pend_pkg.sv
// Package: shared sizes and helpers for the SGI pending-state bank.
// Assumes: 16 SGIs, an 8-slot source field per SGI regardless of how many
// sources are built.
package sgi_pend_pkg;
    localparam int NUM_SGI   = 16;
    localparam int SRC_SLOTS = 8;
    localparam int PAIRS     = NUM_SGI * SRC_SLOTS;
    localparam int WORDS     = NUM_SGI / 4;
    localparam int SGI_W     = $clog2(NUM_SGI);
    localparam int SRC_W     = $clog2(SRC_SLOTS);
    localparam int IDX_W     = SGI_W + SRC_W;

    typedef logic [SGI_W-1:0] sgi_id_t;
    typedef logic [SRC_W-1:0] src_id_t;
    typedef logic [PAIRS-1:0] pair_vec_t;

    // Flat pair index: source slot is the low field.
    function automatic logic [IDX_W-1:0] pair_idx(sgi_id_t g, src_id_t k);
        return {g, k};
    endfunction
endpackage

// File: rtl/sgi_evt_decode.sv
// Module: turns one (valid, SGI, source) event into a one-hot pair mask.
// Assumes: sources at or above NUM_SRC are absent, so events for them drop.
module sgi_evt_decode
    import sgi_pend_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic      vld,
    input  sgi_id_t   sgi,
    input  src_id_t   src,
    output pair_vec_t hit
);
    // Decode the event into the single pair it names.
    always_comb begin
        hit = '0;
        if (vld && (int'(src) < NUM_SRC)) begin
            hit[pair_idx(sgi, src)] = 1'b1;
        end
    end
endmodule

// File: rtl/sgi_win_decode.sv
// Module: address decode for the clear-pending window; builds the per-pair
// clear mask from a write and flags a valid read.
// Assumes: WIN_BASE is 16-byte aligned; the low two address bits are ignored.
module sgi_win_decode
    import sgi_pend_pkg::*;
#(
    parameter int          NUM_SRC  = 8,
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] WIN_BASE = 12'hF10
) (
    input  logic              route_mode,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output pair_vec_t         clr,
    output logic              rd_en,
    output logic [1:0]        rd_word
);
    localparam logic [ADDR_W-1:0] BASE_EXT = ADDR_W'(WIN_BASE);

    logic       in_win;
    logic       wr_en;
    logic [1:0] word;

    // Match the upper address bits against the window base; gate by mode.
    always_comb begin
        in_win  = (bus_addr[ADDR_W-1:4] == BASE_EXT[ADDR_W-1:4]) && !route_mode;
        word    = bus_addr[3:2];
        wr_en   = bus_req && bus_we && in_win;
        rd_en   = bus_req && !bus_we && in_win;
        rd_word = word;
    end

    // Spread the written word over its four SGIs, lane by lane.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar x = 0; x < 4; x++) begin : g_lane
            for (genvar k = 0; k < SRC_SLOTS; k++) begin : g_src
                if (k < NUM_SRC) begin : g_live
                    assign clr[(4*w + x)*SRC_SLOTS + k] =
                        wr_en && (word == 2'(w)) && bus_be[x] && bus_wdata[8*x + k];
                end else begin : g_dead
                    assign clr[(4*w + x)*SRC_SLOTS + k] = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sgi_pair_state.sv
// Module: two-bit state of one (SGI, source) pair.
// Assumes: all event inputs are already decoded to this pair; a raise beats a
// clear, and an acknowledge only acts on a pending pair.
module sgi_pair_state (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic ack,
    input  logic eoi,
    output logic pend,
    output logic act
);
    logic take;

    // An acknowledge is taken only when the pair is pending.
    assign take = ack && pend;

    // Advance pending and active bits; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            act  <= 1'b0;
        end else begin
            pend <= set || (pend && !clr && !take);
            act  <= (act && !eoi) || take;
        end
    end
endmodule

// File: rtl/sgi_pend_bank.sv
// Module: SGI pending-state bank for one processor, with a write-one-to-clear
// read window. Assumes word-aligned bus accesses and a synchronous reset.
module sgi_pend_bank
    import sgi_pend_pkg::*;
#(
    parameter int          NUM_SRC  = 8,
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] WIN_BASE = 12'hF10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              route_mode,
    input  logic              set_vld,
    input  logic [3:0]        set_sgi,
    input  logic [2:0]        set_src,
    input  logic              ack_vld,
    input  logic [3:0]        ack_sgi,
    input  logic [2:0]        ack_src,
    input  logic              eoi_vld,
    input  logic [3:0]        eoi_sgi,
    input  logic [2:0]        eoi_src,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [127:0]      pend_mask,
    output logic [127:0]      act_mask
);
    pair_vec_t  set_hit, ack_hit, eoi_hit, clr_hit;
    logic       rd_en;
    logic [1:0] rd_word;

    sgi_evt_decode #(.NUM_SRC(NUM_SRC)) u_set_dec (
        .vld(set_vld), .sgi(set_sgi), .src(set_src), .hit(set_hit));
    sgi_evt_decode #(.NUM_SRC(NUM_SRC)) u_ack_dec (
        .vld(ack_vld), .sgi(ack_sgi), .src(ack_src), .hit(ack_hit));
    sgi_evt_decode #(.NUM_SRC(NUM_SRC)) u_eoi_dec (
        .vld(eoi_vld), .sgi(eoi_sgi), .src(eoi_src), .hit(eoi_hit));

    sgi_win_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_win (
        .route_mode(route_mode), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .clr(clr_hit), .rd_en(rd_en), .rd_word(rd_word));

    // One state cell per implemented pair; absent sources are tied off.
    for (genvar g = 0; g < NUM_SGI; g++) begin : g_sgi
        for (genvar k = 0; k < SRC_SLOTS; k++) begin : g_src
            localparam int P = g*SRC_SLOTS + k;
            if (k < NUM_SRC) begin : g_cell
                sgi_pair_state u_cell (
                    .clk(clk), .rst_n(rst_n),
                    .set(set_hit[P]), .clr(clr_hit[P]),
                    .ack(ack_hit[P]), .eoi(eoi_hit[P]),
                    .pend(pend_mask[P]), .act(act_mask[P]));
            end else begin : g_none
                assign pend_mask[P] = 1'b0;
                assign act_mask[P]  = 1'b0;
            end
        end
    end

    // Return the addressed word of pending bits, or zero when not selected.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            bus_rdata = pend_mask[rd_word*32 +: 32];
        end
    end
endmodule

// File: rtl/sgi_pend_chk.sv
// Module: property checker for sgi_pend_bank, attached by bind.
// Assumes: inputs are sampled on the rising edge and held stable around it.
module sgi_pend_chk #(
    parameter int          NUM_SRC  = 8,
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] WIN_BASE = 12'hF10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              route_mode,
    input logic              set_vld,
    input logic [3:0]        set_sgi,
    input logic [2:0]        set_src,
    input logic              ack_vld,
    input logic [3:0]        ack_sgi,
    input logic [2:0]        ack_src,
    input logic              eoi_vld,
    input logic [3:0]        eoi_sgi,
    input logic [2:0]        eoi_src,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [127:0]      pend_mask,
    input logic [127:0]      act_mask
);
    localparam logic [ADDR_W-1:0] BASE_EXT = ADDR_W'(WIN_BASE);
    logic [6:0] set_idx, ack_idx, eoi_idx;
    logic       outside;
    assign set_idx = {set_sgi, set_src};
    assign ack_idx = {ack_sgi, ack_src};
    assign eoi_idx = {eoi_sgi, eoi_src};
    assign outside = bus_addr[ADDR_W-1:4] != BASE_EXT[ADDR_W-1:4];

    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (pend_mask == '0) && (act_mask == '0));

    a_r2_r7_set_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vld && (int'(set_src) < NUM_SRC)) |=> pend_mask[$past(set_idx)]);

    a_r10_mode_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        route_mode |-> (bus_rdata == '0));

    a_r12_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        outside |-> (bus_rdata == '0));

    for (genvar i = 0; i < 128; i++) begin : g_pair
        if ((i % 8) < NUM_SRC) begin : g_live
            a_r5_act_held: assert property (@(posedge clk) disable iff (!rst_n)
                (act_mask[i] && !(eoi_vld && eoi_idx == 7'(i))) |=> act_mask[i]);
            a_r8_ack_takes: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_vld && ack_idx == 7'(i) && pend_mask[i]) |=> act_mask[i]);
            a_r9_eoi_retires: assert property (@(posedge clk) disable iff (!rst_n)
                (eoi_vld && eoi_idx == 7'(i) && act_mask[i] &&
                 !(ack_vld && ack_idx == 7'(i) && pend_mask[i])) |=> !act_mask[i]);
        end else begin : g_absent
            a_r11_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
                !pend_mask[i] && !act_mask[i]);
        end
    end
endmodule

bind sgi_pend_bank sgi_pend_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .route_mode(route_mode),
    .set_vld(set_vld), .set_sgi(set_sgi), .set_src(set_src),
    .ack_vld(ack_vld), .ack_sgi(ack_sgi), .ack_src(ack_src),
    .eoi_vld(eoi_vld), .eoi_sgi(eoi_sgi), .eoi_src(eoi_src),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .pend_mask(pend_mask), .act_mask(act_mask));

// File: tb/sim_sgi_pend_bank.sv
`timescale 1ns/1ps
// Bench: directed corners, then seeded random traffic, against a bench model.
module sim_sgi_pend_bank;
    localparam int NSRC = 6;
    logic clk = 1'b0, rst_n = 1'b0, route_mode = 1'b0;
    logic set_vld = 0, ack_vld = 0, eoi_vld = 0;
    logic [3:0] set_sgi = 0, ack_sgi = 0, eoi_sgi = 0;
    logic [2:0] set_src = 0, ack_src = 0, eoi_src = 0;
    logic bus_req = 0, bus_we = 0;
    logic [11:0] bus_addr = 0;
    logic [3:0] bus_be = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [127:0] pend_mask, act_mask, mp = '0, ma = '0;
    int nchk = 0, nfail = 0;

    always #4 clk = ~clk;

    sgi_pend_bank #(.NUM_SRC(NSRC)) u0 (.*);

    task automatic chk(string tag, logic [127:0] actual, logic [127:0] expected);
        nchk++;
        if (actual !== expected) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    endtask

    // Expected next state from the requirements, given the driven inputs.
    task automatic tick();
        logic [127:0] np = mp, na = ma;
        for (int i = 0; i < 128; i++) begin
            int g = i / 8; int k = i % 8; int x = g % 4;
            bit impl = (k < NSRC);
            bit s = set_vld && ({set_sgi, set_src} == 7'(i)) && impl;
            bit c = bus_req && bus_we && !route_mode && (bus_addr[11:4] == 8'hF1) &&
                    (int'(bus_addr[3:2]) == g / 4) && bus_be[x] && bus_wdata[8*x + k] && impl;
            bit a = ack_vld && ({ack_sgi, ack_src} == 7'(i)) && impl && mp[i];
            bit e = eoi_vld && ({eoi_sgi, eoi_src} == 7'(i)) && impl;
            np[i] = s || (mp[i] && !c && !a);
            na[i] = (ma[i] && !e) || a;
        end
        @(posedge clk);
        mp = np; ma = na;
        @(negedge clk);
        set_vld = 0; ack_vld = 0; eoi_vld = 0; bus_req = 0; bus_we = 0;
    endtask

    task automatic check_state(string tag);
        chk(tag, pend_mask, mp);
        chk(tag, act_mask, ma);
    endtask

    // Combinational read of one address, compared with the model.
    task automatic rd(string tag, logic [11:0] addr);
        logic [31:0] exp = '0;
        bus_req = 1; bus_we = 0; bus_addr = addr;
        if (!route_mode && addr[11:4] == 8'hF1) exp = mp[addr[3:2]*32 +: 32];
        #1 chk(tag, {96'd0, bus_rdata}, {96'd0, exp});
        bus_req = 0;
    endtask

    task automatic wr(logic [11:0] addr, logic [3:0] be, logic [31:0] d);
        bus_req = 1; bus_we = 1; bus_addr = addr; bus_be = be; bus_wdata = d;
    endtask

    task automatic raise(int g, int k);
        set_vld = 1; set_sgi = 4'(g); set_src = 3'(k);
    endtask

    initial begin
        repeat (20000 * 10) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_state("R1 reset");
        for (int n = 0; n < 4; n++) rd("R1 reset read", 12'hF10 + 12'(4*n));

        raise(5, 2); tick(); check_state("R2 raise");
        rd("R3 read pending", 12'hF14);
        chk("R3 value", {96'd0, bus_rdata}, {96'd0, 32'h0000_0400});

        raise(5, 3); wr(12'hF14, 4'hF, 32'h0000_0800); tick();
        check_state("R7 set beats clear");
        chk("R7 bit", {127'd0, pend_mask[43]}, 128'd1);

        wr(12'hF14, 4'b1101, 32'h0000_0C00); tick(); check_state("R6 lane off");
        wr(12'hF14, 4'hF, 32'h0); tick(); check_state("R6 zero data");
        chk("R6 bits", {126'd0, pend_mask[43:42]}, 128'd3);

        wr(12'hF14, 4'b0010, 32'h0000_0400); tick(); check_state("R4 clear");
        chk("R4 bit", {126'd0, pend_mask[42], act_mask[42]}, 128'd0);

        ack_vld = 1; ack_sgi = 5; ack_src = 3; tick(); check_state("R8 ack");
        chk("R8 active", {126'd0, pend_mask[43], act_mask[43]}, 128'd1);
        raise(5, 3); tick(); rd("R3 active-and-pending read", 12'hF14);
        wr(12'hF14, 4'b0010, 32'h0000_0800); tick(); check_state("R5 clear keeps act");
        chk("R5 bits", {126'd0, pend_mask[43], act_mask[43]}, 128'd1);
        eoi_vld = 1; eoi_sgi = 5; eoi_src = 3; tick(); check_state("R9 retire");
        chk("R9 idle", {126'd0, pend_mask[43], act_mask[43]}, 128'd0);

        raise(9, 1); tick();
        ack_vld = 1; ack_sgi = 9; ack_src = 1; raise(9, 1); tick();
        chk("R8 ack with raise", {126'd0, pend_mask[73], act_mask[73]}, 128'd3);
        ack_vld = 1; ack_sgi = 2; ack_src = 0; tick(); check_state("R8 ack idle pair");
        eoi_vld = 1; eoi_sgi = 9; eoi_src = 1; tick();
        chk("R9 back to pending", {126'd0, pend_mask[73], act_mask[73]}, 128'd2);

        route_mode = 1;
        rd("R10 mode read", 12'hF18);
        chk("R10 read zero", {96'd0, bus_rdata}, 128'd0);
        wr(12'hF18, 4'hF, 32'hFFFF_FFFF); tick(); check_state("R10 mode write");
        chk("R10 kept", {127'd0, pend_mask[73]}, 128'd1);
        route_mode = 0;
        rd("R10 reopened", 12'hF18);

        raise(0, 7); tick(); raise(1, 6); tick(); check_state("R11 absent raise");
        rd("R11 absent read", 12'hF10);
        chk("R11 bits", {124'd0, pend_mask[15:14], pend_mask[7:6]}, 128'd0);

        raise(12, 0); tick();
        wr(12'hF20, 4'hF, 32'hFFFF_FFFF); tick(); check_state("R12 outside write");
        wr(12'hF0C, 4'hF, 32'hFFFF_FFFF); tick(); check_state("R12 outside write low");
        rd("R12 outside read", 12'hF20);
        chk("R12 kept", {127'd0, pend_mask[96]}, 128'd1);

        void'($urandom(32'd5150));
        for (int c = 0; c < 3000; c++) begin
            int r = $urandom % 16;
            route_mode = ($urandom % 8) == 0;
            if ($urandom % 2) raise($urandom % 16, $urandom % 8);
            if ($urandom % 3 == 0) begin
                ack_vld = 1; ack_sgi = 4'($urandom); ack_src = 3'($urandom % 8);
            end
            if ($urandom % 3 == 0) begin
                eoi_vld = 1; eoi_sgi = 4'($urandom); eoi_src = 3'($urandom % 8);
            end
            if ($urandom % 2)
                wr((r == 0) ? 12'hF20 : 12'hF10 + 12'(4 * ($urandom % 4)),
                   4'($urandom), $urandom & $urandom);
            tick();
            check_state("R2/R4/R5/R8/R9 random");
            rd("R3/R10/R12 random read", (r == 1) ? 12'h010 : 12'hF10 + 12'(4 * ($urandom % 4)));
        end
        summary();
    end
endmodule